// File: doc/BRIEF.md
# Hot-Swap Socket Power Sequencer

This block is the host-side controller for a single removable-card socket. It filters the two card-detect contacts and, once a card is accepted, reads the two voltage-sense contacts while the socket is still unpowered. It then switches on either the 3.3 V or the 5 V supply, or turns the card away if the sense code asks for a voltage the socket cannot provide. During a settling window after power-up the data bus and the card's RESET line stay released (high impedance). The block then drives the bus and holds RESET asserted for a set time, releases it, and waits for the card to report READY. When READY arrives, a flag tells software that the card's configuration space may now be read.

Removing the card takes the socket cold straight away, from any state. Software can ask for the other supply voltage while the card is ready. The sequencer then turns off both supplies for a discharge time before it runs the power-up sequence again at the new voltage. Every time constant is a parameter counted in clock cycles.

Top module: `sock_pwr_seq`

## Requirements
- R1: A card counts as present only after both detect inputs `cd_n` have read low for DEB_CYC consecutive clocks, after a two-flop synchroniser. A shorter low pulse leaves the status at empty. Removal is filtered the same way.
- R2: The sense code is decoded when a card is accepted. `vs1_n`=0 with `vs2_n`=1 selects 3.3 V (`en_3v3`). `vs1_n`=1 with `vs2_n`=1 selects 5 V (`en_5v`). Any code with `vs2_n`=0 is rejected: status becomes 1 and no supply is enabled until the card is removed.
- R3: The sense inputs are read only in the cycle a card is accepted. Later changes on them do not change the enabled supply.
- R4: `en_3v3` and `en_5v` are never high at the same time.
- R5: After a supply turns on, `bus_oe` and `card_reset` stay low for exactly PWR_CYC cycles.
- R6: At the end of the settling window, `bus_oe` rises together with `card_reset`. `card_reset` then stays high for exactly RST_CYC cycles.
- R7: Once reset is released, a high on `ready_in` moves the block to ready: `cis_ready`=1 and status 5, with the bus still enabled.
- R8: If `ready_in` stays low for RDY_CYC cycles after reset release, status becomes error (6). Both supplies, `bus_oe` and `cis_ready` go low and stay low until the card is removed.
- R9: A filtered removal in any state returns the block to empty (status 0) with both supplies, `bus_oe`, `card_reset` and `cis_ready` low.
- R10: In the ready state, a `vreq_valid` pulse whose `vreq_sel` (0 = 3.3 V, 1 = 5 V) differs from the present voltage switches off both supplies and the bus for exactly DIS_CYC cycles (status 7). The other supply then comes on and the full settle/reset/ready sequence runs again. A request for the voltage already applied is ignored.
- R11: `status` encodes the state as follows: 0 empty, 1 rejected, 2 powering, 3 resetting, 4 waiting for READY, 5 ready, 6 error, 7 discharging.
- R12: While `rst_n` is low and just after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cd_n | input | 2 | Card-detect contacts, low when seated |
| vs1_n | input | 1 | Voltage-sense 1, low when grounded by the card |
| vs2_n | input | 1 | Voltage-sense 2, low when grounded by the card |
| ready_in | input | 1 | Card READY, high when ready |
| vreq_valid | input | 1 | One-cycle software voltage-change request |
| vreq_sel | input | 1 | Requested voltage: 0 = 3.3 V, 1 = 5 V |
| en_3v3 | output | 1 | 3.3 V supply enable |
| en_5v | output | 1 | 5 V supply enable |
| bus_oe | output | 1 | Host interface drive enable (0 = high impedance) |
| card_reset | output | 1 | RESET to the card (valid when bus_oe=1) |
| cis_ready | output | 1 | Card ready for configuration-space read |
| status | output | 3 | State code per R11 |

## Verification
The hardest case to set up from the ports is a voltage change. It needs a card that has already passed through debounce, settling, reset and READY. A same-voltage request must then be shown to be ignored before a real change is issued. The stimulus seats a 3.3 V card with READY held high, waits for status 5, and pulses a 3.3 V request. It then pulses a 5 V request and measures the cycles between `en_3v3` falling and `en_5v` rising. The sense-after-power rule is checked by flipping `vs1_n` in the middle of the settling window.

// File: rtl/sps_pkg.sv
// Package: shared state encoding and voltage codes for the socket sequencer.
// Assumes: status codes are read by software, so their values are fixed.
package sps_pkg;
    typedef enum logic [2:0] {
        ST_EMPTY  = 3'd0,
        ST_REJECT = 3'd1,
        ST_POWER  = 3'd2,
        ST_RESET  = 3'd3,
        ST_WAIT   = 3'd4,
        ST_READY  = 3'd5,
        ST_ERROR  = 3'd6,
        ST_DISCH  = 3'd7
    } sps_state_e;

    localparam logic VOLT_3V3 = 1'b0;
    localparam logic VOLT_5V  = 1'b1;
endpackage

// File: rtl/sps_debounce.sv
// Module: card-detect filter. Synchronises both detect contacts and flips the
// accepted presence only after the raw value has differed for DEB_CYC clocks.
// Assumes: a card is seated only when both contacts read low.
module sps_debounce #(
    parameter int DEB_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cd_n,
    output logic       present
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic [1:0]    sync1, sync2;
    logic          raw;
    logic [CW-1:0] run_cnt;

    // Two-flop synchroniser for the asynchronous detect contacts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 2'b11;
            sync2 <= 2'b11;
        end else begin
            sync1 <= cd_n;
            sync2 <= sync1;
        end
    end

    assign raw = (sync2 == 2'b00);

    // Count consecutive disagreeing cycles and accept the new value at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present <= 1'b0;
            run_cnt <= '0;
        end else if (raw == present) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(DEB_CYC - 1)) begin
            present <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_flip_follows_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(present) |-> $past(raw) == present);
endmodule

// File: rtl/sps_timer.sv
// Module: loadable down-counter shared by all sequencing windows.
// Assumes: a load and an expiry never need to happen in the same cycle by intent;
// a load always wins.
module sps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load a window length or count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    assert_timer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
endmodule

// File: rtl/sps_fsm.sv
// Module: socket sequencing state machine. Decodes the sense code on acceptance,
// runs settle, reset, READY wait and discharge windows, and drives the supply,
// bus and status outputs from the state register.
// Assumes: 'present' is already debounced and 'tzero' comes from sps_timer.
module sps_fsm
    import sps_pkg::*;
#(
    parameter int PWR_CYC = 20,
    parameter int RST_CYC = 6,
    parameter int RDY_CYC = 30,
    parameter int DIS_CYC = 10,
    parameter int TW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          present,
    input  logic          vs1_n,
    input  logic          vs2_n,
    input  logic          ready_in,
    input  logic          vreq_valid,
    input  logic          vreq_sel,
    input  logic          tzero,
    output logic          tload,
    output logic [TW-1:0] tval,
    output logic          en_3v3,
    output logic          en_5v,
    output logic          bus_oe,
    output logic          card_reset,
    output logic          cis_ready,
    output logic [2:0]    status
);
    sps_state_e st, st_nxt;
    logic       volt, volt_nxt;
    logic       pend, pend_nxt;
    logic       powered;

    // Next-state, window loads and voltage selection.
    always_comb begin
        st_nxt   = st;
        volt_nxt = volt;
        pend_nxt = pend;
        tload    = 1'b0;
        tval     = '0;
        if (!present && st != ST_EMPTY) begin
            st_nxt = ST_EMPTY;
        end else begin
            case (st)
                ST_EMPTY: if (present) begin
                    if (!vs2_n) begin
                        st_nxt = ST_REJECT;
                    end else begin
                        volt_nxt = vs1_n ? VOLT_5V : VOLT_3V3;
                        st_nxt   = ST_POWER;
                        tload    = 1'b1;
                        tval     = TW'(PWR_CYC - 1);
                    end
                end
                ST_POWER: if (tzero) begin
                    st_nxt = ST_RESET;
                    tload  = 1'b1;
                    tval   = TW'(RST_CYC - 1);
                end
                ST_RESET: if (tzero) begin
                    st_nxt = ST_WAIT;
                    tload  = 1'b1;
                    tval   = TW'(RDY_CYC - 1);
                end
                ST_WAIT: begin
                    if (ready_in)   st_nxt = ST_READY;
                    else if (tzero) st_nxt = ST_ERROR;
                end
                ST_READY: if (vreq_valid && vreq_sel != volt) begin
                    pend_nxt = vreq_sel;
                    st_nxt   = ST_DISCH;
                    tload    = 1'b1;
                    tval     = TW'(DIS_CYC - 1);
                end
                ST_DISCH: if (tzero) begin
                    volt_nxt = pend;
                    st_nxt   = ST_POWER;
                    tload    = 1'b1;
                    tval     = TW'(PWR_CYC - 1);
                end
                default: ;
            endcase
        end
    end

    // State, selected voltage and pending request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_EMPTY;
            volt <= VOLT_3V3;
            pend <= VOLT_3V3;
        end else begin
            st   <= st_nxt;
            volt <= volt_nxt;
            pend <= pend_nxt;
        end
    end

    // Output decode from the state register.
    always_comb begin
        powered    = (st == ST_POWER) || (st == ST_RESET) ||
                     (st == ST_WAIT)  || (st == ST_READY);
        en_3v3     = powered && (volt == VOLT_3V3);
        en_5v      = powered && (volt == VOLT_5V);
        bus_oe     = (st == ST_RESET) || (st == ST_WAIT) || (st == ST_READY);
        card_reset = (st == ST_RESET);
        cis_ready  = (st == ST_READY);
        status     = st;
    end

    assert_one_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_3v3 && en_5v));
    assert_through_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_5v |-> !$past(en_3v3)) and (en_3v3 |-> !$past(en_5v)));
    assert_bus_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(en_3v3 || en_5v));
    assert_cis_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cis_ready |-> (bus_oe && !card_reset && (en_3v3 || en_5v)));
    assert_volt_cold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(volt) |-> $past(!en_3v3 && !en_5v));
    assert_empty_cold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0) |-> !(en_3v3 || en_5v || bus_oe));
endmodule

// File: rtl/sock_pwr_seq.sv
// Module: top of the socket power sequencer. Connects the detect filter, the
// window timer and the sequencing state machine.
// Assumes: all time constants are given in clock cycles and are at least 1.
module sock_pwr_seq #(
    parameter int DEB_CYC = 50_000,
    parameter int PWR_CYC = 5_000_000,
    parameter int RST_CYC = 500,
    parameter int RDY_CYC = 250_000_000,
    parameter int DIS_CYC = 5_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cd_n,
    input  logic       vs1_n,
    input  logic       vs2_n,
    input  logic       ready_in,
    input  logic       vreq_valid,
    input  logic       vreq_sel,
    output logic       en_3v3,
    output logic       en_5v,
    output logic       bus_oe,
    output logic       card_reset,
    output logic       cis_ready,
    output logic [2:0] status
);
    localparam int MAX_A = (PWR_CYC > RST_CYC) ? PWR_CYC : RST_CYC;
    localparam int MAX_B = (RDY_CYC > DIS_CYC) ? RDY_CYC : DIS_CYC;
    localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAX_W + 1);

    logic          present;
    logic          tload;
    logic          tzero;
    logic [TW-1:0] tval;

    sps_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk(clk), .rst_n(rst_n), .cd_n(cd_n), .present(present)
    );

    sps_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .zero(tzero)
    );

    sps_fsm #(
        .PWR_CYC(PWR_CYC), .RST_CYC(RST_CYC), .RDY_CYC(RDY_CYC),
        .DIS_CYC(DIS_CYC), .TW(TW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .present(present),
        .vs1_n(vs1_n), .vs2_n(vs2_n), .ready_in(ready_in),
        .vreq_valid(vreq_valid), .vreq_sel(vreq_sel),
        .tzero(tzero), .tload(tload), .tval(tval),
        .en_3v3(en_3v3), .en_5v(en_5v), .bus_oe(bus_oe),
        .card_reset(card_reset), .cis_ready(cis_ready), .status(status)
    );
endmodule

// File: tb/sock_pwr_seq_bench.sv
`timescale 1ns/1ps
module sock_pwr_seq_bench;
    localparam int DEB = 4;
    localparam int PWR = 20;
    localparam int RST = 6;
    localparam int RDY = 30;
    localparam int DIS = 10;

    // {vs1_n, vs2_n, exp_3v3, exp_5v, exp_bus, exp_status[2:0]}
    localparam logic [7:0] VEC [0:3] = '{
        8'b0_1_1_0_1_101,
        8'b1_1_0_1_1_101,
        8'b0_0_0_0_0_001,
        8'b1_0_0_0_0_001
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cd_n = 2'b11;
    logic       vs1_n = 1'b1, vs2_n = 1'b1;
    logic       ready_in = 1'b0, vreq_valid = 1'b0, vreq_sel = 1'b0;
    logic       en_3v3, en_5v, bus_oe, card_reset, cis_ready;
    logic [2:0] status;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic both_on = 1'b0;

    always #2.5 clk = ~clk;

    sock_pwr_seq #(.DEB_CYC(DEB), .PWR_CYC(PWR), .RST_CYC(RST),
                   .RDY_CYC(RDY), .DIS_CYC(DIS)) u_sock_pwr_seq (
        .clk(clk), .rst_n(rst_n), .cd_n(cd_n), .vs1_n(vs1_n), .vs2_n(vs2_n),
        .ready_in(ready_in), .vreq_valid(vreq_valid), .vreq_sel(vreq_sel),
        .en_3v3(en_3v3), .en_5v(en_5v), .bus_oe(bus_oe),
        .card_reset(card_reset), .cis_ready(cis_ready), .status(status)
    );

    // Watchdog and supply-overlap monitor (R4).
    always @(negedge clk) begin
        cyc++;
        if (en_3v3 && en_5v) both_on = 1'b1;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count negedges until the output vector matches; returns -1 on timeout.
    task automatic count_until(input int which, input logic val, output int n);
        logic s;
        n = 0;
        for (int i = 0; i < 500; i++) begin
            case (which)
                0: s = en_3v3;
                1: s = en_5v;
                2: s = bus_oe;
                3: s = card_reset;
                default: s = (status == 3'd6);
            endcase
            if (s == val) return;
            @(negedge clk);
            n++;
        end
        n = -1;
    endtask

    task automatic remove_card();
        cd_n = 2'b11;
        idle(DEB + 6);
    endtask

    initial begin
        int n;
        idle(3);
        // R12: reset state
        chk("R12 outputs in reset", {en_3v3, en_5v, bus_oe, card_reset, cis_ready}, 0);
        chk("R12 status in reset", status, 0);
        rst_n = 1'b1;
        idle(2);
        chk("R12 status after reset", status, 0);

        // R1: glitch of DEB-1 cycles ignored
        vs1_n = 1'b0; vs2_n = 1'b1;
        cd_n = 2'b00; idle(DEB - 1); cd_n = 2'b11;
        idle(15);
        chk("R1 short detect pulse ignored", status, 0);
        chk("R1 no supply after glitch", {en_3v3, en_5v}, 0);
        cd_n = 2'b10; idle(DEB + 4); cd_n = 2'b11;
        chk("R1 one contact only ignored", status, 0);

        // R2/R7/R9/R11: sense code table
        ready_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            vs1_n = VEC[k][7]; vs2_n = VEC[k][6];
            cd_n = 2'b00;
            idle(80);
            chk("R2 en_3v3 for sense code", en_3v3, VEC[k][5]);
            chk("R2 en_5v for sense code", en_5v, VEC[k][4]);
            chk("R7 bus_oe at end of sequence", bus_oe, VEC[k][3]);
            chk("R11 status for sense code", status, VEC[k][2:0]);
            chk("R7 cis_ready", cis_ready, (VEC[k][2:0] == 3'd5) ? 1 : 0);
            remove_card();
            chk("R9 status after removal", status, 0);
            chk("R9 all off after removal", {en_3v3, en_5v, bus_oe, card_reset, cis_ready}, 0);
        end

        // R5/R6/R3/R8: window timing, late sense change, READY timeout
        ready_in = 1'b0; vs1_n = 1'b0; vs2_n = 1'b1;
        cd_n = 2'b00;
        count_until(0, 1'b1, n);
        chk("R11 status powering", status, 2);
        vs1_n = 1'b1;
        count_until(2, 1'b1, n);
        chk("R5 settle window cycles", n, PWR);
        chk("R6 reset asserted with bus", card_reset, 1);
        chk("R11 status resetting", status, 3);
        count_until(3, 1'b0, n);
        chk("R6 reset width cycles", n, RST);
        chk("R11 status waiting", status, 4);
        count_until(4, 1'b1, n);
        chk("R8 READY timeout cycles", n, RDY);
        chk("R8 all off in error", {en_3v3, en_5v, bus_oe, cis_ready}, 0);
        chk("R3 sense change ignored after power", en_5v, 0);
        idle(10);
        chk("R8 error held", status, 6);
        remove_card();
        chk("R9 removal from error", status, 0);

        // R10: voltage change through zero
        vs1_n = 1'b0; ready_in = 1'b1;
        cd_n = 2'b00;
        idle(60);
        chk("R7 ready before change", status, 5);
        vreq_sel = 1'b0; vreq_valid = 1'b1; idle(1); vreq_valid = 1'b0;
        idle(5);
        chk("R10 same-voltage request ignored", {status, en_3v3}, {3'd5, 1'b1});
        vreq_sel = 1'b1; vreq_valid = 1'b1; idle(1); vreq_valid = 1'b0;
        count_until(0, 1'b0, n);
        chk("R10 discharge status", status, 7);
        chk("R10 bus off in discharge", bus_oe, 0);
        count_until(1, 1'b1, n);
        chk("R10 discharge cycles", n, DIS);
        idle(PWR + RST + 4);
        chk("R10 ready again at 5 V", {status, en_5v, en_3v3}, {3'd5, 1'b1, 1'b0});
        remove_card();

        // R9: removal mid-settle
        cd_n = 2'b00;
        count_until(0, 1'b1, n);
        idle(3);
        remove_card();
        chk("R9 removal during settle", {status, en_3v3, en_5v, bus_oe}, 0);

        chk("R4 supplies never both on", both_on, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule